// File: doc/BRIEF.md
# Pulse Add/Delete Frequency Stage

This block sits between the loop counter of a digital phase-locked loop and the external divide-by-N counter. It runs from a clock at 2N times the loop centre frequency. With no correction pending, it emits a one-cycle output strobe on every second falling edge of that clock. The strobe stream therefore runs at half the input rate, which is N times the centre frequency. Each output strobe counts as one pulse, and the divide-by-N counter downstream uses the strobe as its count enable.

Correction requests arrive from the loop counter's clock domain as toggle-encoded signals: one for "carry" (the output should gain a pulse) and one for "borrow" (the output should lose a pulse). Each request is synchronised into this block's falling-edge domain and added to a signed net pending count. The generator applies the count one step at a time. A positive count fills the next otherwise-empty slot with an extra strobe. A negative count blanks the next slot that would otherwise carry a strobe. Carries and borrows therefore cancel arithmetically, and every strobe is a clean, registered, one-cycle pulse.

Top module: `pulse_adj`

## Requirements
- R1: While rst_n is low, strobe_out is 0 and no correction is pending. After release, the first falling edge leaves strobe_out at 0 and the second sets it to 1.
- R2: With neither request input changing, strobe_out is high after every second falling edge and low after the others, so the strobe count is exactly half the number of clock cycles.
- R3: Every change of carry_tgl, in either direction, adds exactly one strobe to the output. The extra strobe occupies a slot that would otherwise be low.
- R4: Every change of borrow_tgl, in either direction, removes exactly one strobe from the output. The removed strobe is one that would otherwise be high.
- R5: All state, including strobe_out, changes only on falling edges of clk. strobe_out is stable across every rising edge.
- R6: A carry change and a borrow change synchronised in the same cycle cancel. The strobe pattern continues exactly as in R2.
- R7: Requests accumulate in a signed net count that saturates at plus or minus (2^(NET_W-1)-1). At most one correction is applied per slot, so a train of separate requests delivers every one of them while the count stays within range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock at 2N times the centre frequency; the block acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| carry_tgl | input | 1 | Toggle-encoded carry request from the loop counter domain; each change asks for one extra pulse |
| borrow_tgl | input | 1 | Toggle-encoded borrow request from the loop counter domain; each change asks for one pulse fewer |
| strobe_out | output | 1 | One-cycle output strobe, nominally on every second cycle |

## Verification
The bench sweeps zero to three carries against zero to three borrows, at two request spacings, and counts strobes over a fixed window. A stage that lost a request, applied one twice, or let a delete land in an empty slot would miss the expected total by one or more. Toggles in both directions are used, so a design that reacted to only one edge of a toggle would also be caught. A carry and a borrow toggled together must leave the alternating pattern intact cycle by cycle; a design that applied both instead of cancelling them would show a doubled or missing strobe. The strobe is also sampled on both sides of each rising edge, which exposes a stage clocked on the wrong edge.

// File: rtl/pa_pkg.sv
package pa_pkg;

  // Next value of the signed pending count: requests add, applied
  // corrections retire, and the result saturates at +/- lim.
  function automatic int net_next(int net, logic up, logic dn,
                                  logic ins, logic del, int lim);
    int r;
    r = net + int'(up) - int'(dn) - int'(ins) + int'(del);
    if (r > lim)  r = lim;
    if (r < -lim) r = -lim;
    return r;
  endfunction

  // Nominal strobe for a slot: the slot whose phase bit is 1 carries a pulse.
  function automatic logic nominal_strobe(logic phase);
    return phase;
  endfunction

endpackage

// File: rtl/pa_toggle_sync.sv
module pa_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic evt
);
  // chain[0..STAGES-1] synchronise; chain[STAGES] keeps the previous value
  logic [STAGES:0] chain;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], tgl_in};
  end

  assign evt = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/pa_net_pending.sv
module pa_net_pending
  import pa_pkg::*;
#(
  parameter int NET_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carry_evt,
  input  logic borrow_evt,
  input  logic ins_fire,
  input  logic del_fire,
  output logic ins_want,
  output logic del_want,
  output logic net_zero
);
  localparam int LIM = (2 ** (NET_W - 1)) - 1;

  logic signed [NET_W-1:0] net;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) net <= '0;
    else net <= NET_W'(net_next(int'(net), carry_evt, borrow_evt,
                                ins_fire, del_fire, LIM));
  end

  assign ins_want = (net > 0);
  assign del_want = (net < 0);
  assign net_zero = (net == 0);

  // R3: an applied insert retires exactly one unit of positive count
  assert_ins_retires_R3: assert property (@(negedge clk) disable iff (!rst_n)
    (ins_fire && !carry_evt && !borrow_evt) |=> ($past(net) - net == 1));

  // R4: an applied delete retires exactly one unit of negative count
  assert_del_retires_R4: assert property (@(negedge clk) disable iff (!rst_n)
    (del_fire && !carry_evt && !borrow_evt) |=> (net - $past(net) == 1));

  // R6: simultaneous carry and borrow leave the count untouched
  assert_cancel_R6: assert property (@(negedge clk) disable iff (!rst_n)
    (carry_evt && borrow_evt && !ins_fire && !del_fire) |=> $stable(net));

  // R7: the count never leaves its saturation range
  assert_sat_range_R7: assert property (@(negedge clk) disable iff (!rst_n)
    (int'(net) <= LIM) && (int'(net) >= -LIM));
endmodule

// File: rtl/pa_strobe_gen.sv
module pa_strobe_gen
  import pa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ins_want,
  input  logic del_want,
  output logic ins_fire,
  output logic del_fire,
  output logic strobe
);
  logic phase;

  // inserts go into empty slots, deletes into full ones
  assign ins_fire = ins_want && !nominal_strobe(phase);
  assign del_fire = del_want &&  nominal_strobe(phase);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= 1'b0;
      strobe <= 1'b0;
    end else begin
      phase  <= ~phase;
      strobe <= ins_fire | (nominal_strobe(phase) & ~del_fire);
    end
  end

  // R3: an insert produces a strobe in the following cycle
  assert_ins_strobe_R3: assert property (@(negedge clk) disable iff (!rst_n)
    ins_fire |=> strobe);

  // R4: a delete blanks the strobe in the following cycle
  assert_del_blank_R4: assert property (@(negedge clk) disable iff (!rst_n)
    del_fire |=> !strobe);
endmodule

// File: rtl/pulse_adj.sv
module pulse_adj #(
  parameter int SYNC_STAGES = 2,
  parameter int NET_W       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carry_tgl,
  input  logic borrow_tgl,
  output logic strobe_out
);
  localparam int NREQ = 2;

  logic [NREQ-1:0] req_tgl;
  logic [NREQ-1:0] req_evt;
  logic ins_want, del_want, ins_fire, del_fire, net_zero;

  assign req_tgl = {borrow_tgl, carry_tgl};

  for (genvar g = 0; g < NREQ; g++) begin : g_sync
    pa_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tgl_in (req_tgl[g]),
      .evt    (req_evt[g])
    );
  end

  pa_net_pending #(.NET_W(NET_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .carry_evt  (req_evt[0]),
    .borrow_evt (req_evt[1]),
    .ins_fire   (ins_fire),
    .del_fire   (del_fire),
    .ins_want   (ins_want),
    .del_want   (del_want),
    .net_zero   (net_zero)
  );

  pa_strobe_gen u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_want (ins_want),
    .del_want (del_want),
    .ins_fire (ins_fire),
    .del_fire (del_fire),
    .strobe   (strobe_out)
  );

  // cycles since reset, for the alternation check only
  logic [1:0] age;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1: reset holds the strobe low and nothing pending
  always @(negedge clk) begin
    if (!rst_n) assert_reset_state_R1: assert (!strobe_out && net_zero);
  end

  // R2: with nothing pending, the strobe alternates every cycle
  assert_alternate_R2: assert property (@(negedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(net_zero) && $past(net_zero, 2))
      |-> (strobe_out != $past(strobe_out)));

  // insert and delete never act in the same slot
  assert_one_action_R7: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0({ins_fire, del_fire}));
endmodule

// File: tb/pulse_adj_test.sv
module pulse_adj_test;
  logic clk = 1'b1;
  logic rst_n = 1'b0;
  logic carry_tgl = 1'b0;
  logic borrow_tgl = 1'b0;
  logic strobe_out;

  int n_checks = 0;
  int n_fail = 0;

  localparam int WIN = 120;

  always #4 clk = ~clk;

  pulse_adj uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .carry_tgl  (carry_tgl),
    .borrow_tgl (borrow_tgl),
    .strobe_out (strobe_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    carry_tgl = 1'b0;
    borrow_tgl = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
  endtask

  // k carries at 5+n*sp, j borrows at 6+n*sp (or same cycle when same=1)
  task automatic run_case(input int k, input int j, input int sp, input bit same,
                          output int cnt, output int pat_err);
    cnt = 0;
    pat_err = 0;
    do_reset();
    for (int i = 1; i <= WIN; i++) begin
      @(posedge clk);
      if (strobe_out) cnt++;
      if (strobe_out != ((i % 2) == 0)) pat_err++;
      for (int n = 0; n < k; n++)
        if (i == 5 + n * sp) carry_tgl = ~carry_tgl;
      for (int n = 0; n < j; n++)
        if (i == (same ? 5 : 6) + n * sp) borrow_tgl = ~borrow_tgl;
    end
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int cnt, perr;
    int first_a, first_b;
    int mism;

    // R1: reset state
    repeat (2) @(posedge clk);
    check(strobe_out == 1'b0, "R1 reset strobe", strobe_out, 0);

    // R1: first strobe on second falling edge after release
    rst_n = 1'b1;
    @(posedge clk); first_a = strobe_out;
    @(posedge clk); first_b = strobe_out;
    check(first_a == 0 && first_b == 1, "R1 first strobe", first_a * 2 + first_b, 1);

    // R2: nominal alternation and half rate
    run_case(0, 0, 3, 1'b0, cnt, perr);
    check(perr == 0, "R2 alternation errors", perr, 0);

    // R5: strobe stable across rising edges
    mism = 0;
    for (int c = 0; c < 20; c++) begin
      logic a, b;
      @(negedge clk);
      #3 a = strobe_out;
      #2 b = strobe_out;
      if (a != b) mism++;
    end
    check(mism == 0, "R5 change at rising edge", mism, 0);

    // R3 R4 R7: sweep of carry and borrow counts
    for (int sp = 3; sp <= 7; sp += 4)
      for (int k = 0; k < 4; k++)
        for (int j = 0; j < 4; j++) begin
          run_case(k, j, sp, 1'b0, cnt, perr);
          check(cnt == WIN / 2 + k - j, $sformatf("R3 R4 R7 k=%0d j=%0d sp=%0d", k, j, sp),
                cnt, WIN / 2 + k - j);
        end

    // R6: simultaneous carry and borrow cancel, pattern untouched
    run_case(2, 2, 7, 1'b1, cnt, perr);
    check(perr == 0 && cnt == WIN / 2, "R6 cancel pattern errors", perr, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule